// File: doc/BRIEF.md
# Power-gating sequencer

This block drives every control line of one switchable power domain. A power-down request starts a fixed sequence: the domain outputs are clamped, the retention registers are told to save, and then the supply switch is opened. A power-up request runs the reverse: the switch is closed, the domain reset is held, the retention registers are told to restore, and finally the clamps are released. Each step lasts a programmable number of clock cycles, and the next step begins only when that count has run out.

The block can drive retention in two ways. The first is a pair of single-cycle save and restore strobes. The second is one active-low retain level, and a parameter picks which. A small clamp stage sits on the domain's output bus. While isolation is active it presents zero, all ones or the last value that passed through. A request that goes against a sequence already running is held and then served. A request for the state the domain is already in or heading to is dropped.

States (pgs_state_e): S_ON (idle, powered), S_ISO, S_SAVE, S_CUT (down steps), S_OFF (idle, gated), S_PWR, S_RST, S_REST (up steps). Transitions: S_ON→S_ISO on a down request or a held one; S_ISO→S_SAVE→S_CUT→S_OFF and S_PWR→S_RST→S_REST→S_ON, each when the step counter runs out; S_OFF→S_PWR on an up request or a held one.

Top module: `power_gate_seq`

## Requirements
- R1: After reset, dom_on=1, iso_en=0, pwr_off=0, dom_rst_n=1, retain_n=1, save_p=0, restore_p=0 and seq_done=0.
- R2: A down request sampled at edge s raises iso_en in cycle s. The save step begins in cycle s+N and pwr_off rises in cycle s+2N, where N is the step length.
- R3: An up request sampled at edge s drops pwr_off in cycle s. The reset step begins in cycle s+N, the restore step begins in cycle s+2N, and iso_en falls in cycle s+3N.
- R4: The step length N equals step_wait, except that a step_wait of 0 is treated as 1.
- R5: In strobe style (RETAIN_STYLE=0), save_p and restore_p are each high for exactly one cycle, at the first cycle of the save step and of the restore step. retain_n stays 1 in this style.
- R6: In level style (RETAIN_STYLE=1), retain_n goes low at the start of the save step and returns high at the start of the restore step. save_p and restore_p stay 0 in this style.
- R7: seq_done is high for one cycle, the cycle in which a sequence completes (s+3N). dom_on is 1 only while idle and powered.
- R8: An opposite-direction request received during a sequence is held, and that sequence starts in the cycle after the running one completes.
- R9: A request for the direction the domain is already in or running toward causes no output change.
- R10: If both requests arrive in the same cycle while idle, the transition away from the current state runs first and the other request is held as in R8.
- R11: With iso_en=0, dom_data_out equals dom_data_in. With iso_en=1, it equals all zeros (CLAMP_MODE=0), all ones (CLAMP_MODE=1) or the value present in the last cycle before isolation (CLAMP_MODE=2).
- R12: dom_rst_n is low for exactly the N cycles of the reset step, and only while the supply is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| pwr_dn_req | input | 1 | Power-down request pulse |
| pwr_up_req | input | 1 | Power-up request pulse |
| step_wait | input | WAIT_W | Cycles per step (0 acts as 1) |
| dom_data_in | input | DATA_W | Raw outputs of the gated domain |
| dom_data_out | output | DATA_W | Domain outputs after the clamp |
| iso_en | output | 1 | Isolation enable |
| save_p | output | 1 | Save strobe (strobe style) |
| restore_p | output | 1 | Restore strobe (strobe style) |
| retain_n | output | 1 | Retain level, active low (level style) |
| pwr_off | output | 1 | Supply switch open when 1 |
| dom_rst_n | output | 1 | Domain reset, active low |
| seq_done | output | 1 | One-cycle completion pulse |
| dom_on | output | 1 | Domain idle and powered |

## Verification
Two things can land in the same cycle: a sequence finishing and an opposite request being accepted. The held request must start in the very next cycle, after the done pulse and with no gap. The bench provokes this by sending an up request in the middle of a power-down and by raising both requests together while idle in each state. A scoreboard checks that the second sequence's first edge comes exactly one cycle after the first sequence's done pulse. The scoreboard stamps every output transition with its cycle number, so a missing, doubled or late step shows up as a mismatch.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
    typedef enum logic [2:0] {
        S_ON   = 3'd0,
        S_ISO  = 3'd1,
        S_SAVE = 3'd2,
        S_CUT  = 3'd3,
        S_OFF  = 3'd4,
        S_PWR  = 3'd5,
        S_RST  = 3'd6,
        S_REST = 3'd7
    } pgs_state_e;
endpackage

// File: rtl/pgs_step_timer.sv
module pgs_step_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] wait_in,
    output logic              expire
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (wait_in == '0) ? '0 : wait_in - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);

    // R4: a freshly loaded step lasts at least one cycle before expiring is acted on
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt_q) != '0 && !$past(load)) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pgs_iso_clamp.sv
module pgs_iso_clamp #(
    parameter int DATA_W     = 8,
    parameter int CLAMP_MODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iso_en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    localparam logic [DATA_W-1:0] FIXED_VAL = (CLAMP_MODE == 1) ? '1 : '0;
    localparam bit USE_HOLD = (CLAMP_MODE == 2);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] clamp_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else if (!iso_en)
            hold_q <= d;
    end

    assign clamp_v = USE_HOLD ? hold_q : FIXED_VAL;
    assign q       = iso_en ? clamp_v : d;

    // R11: while isolation stays on, the clamped value does not move
    a_r11_clamp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_en && $past(iso_en)) |-> $stable(q));
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
    import pgs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dn_req,
    input  logic up_req,
    input  logic step_expire,
    output logic step_load,
    output logic iso_o,
    output logic sw_off_o,
    output logic dom_rst_n_o,
    output logic retained_o,
    output logic save_o,
    output logic restore_o,
    output logic done_o,
    output logic on_o
);
    pgs_state_e state_q, state_d;
    logic fresh_q;
    logic up_pend_q, dn_pend_q;
    logic down_seq, up_seq, dn_go, up_go;

    assign down_seq = (state_q == S_ISO) || (state_q == S_SAVE) || (state_q == S_CUT);
    assign up_seq   = (state_q == S_PWR) || (state_q == S_RST)  || (state_q == S_REST);
    assign dn_go    = (state_q == S_ON)  && (dn_req || dn_pend_q);
    assign up_go    = (state_q == S_OFF) && (up_req || up_pend_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ON:   if (dn_go)       state_d = S_ISO;
            S_ISO:  if (step_expire) state_d = S_SAVE;
            S_SAVE: if (step_expire) state_d = S_CUT;
            S_CUT:  if (step_expire) state_d = S_OFF;
            S_OFF:  if (up_go)       state_d = S_PWR;
            S_PWR:  if (step_expire) state_d = S_RST;
            S_RST:  if (step_expire) state_d = S_REST;
            S_REST: if (step_expire) state_d = S_ON;
        endcase
    end

    assign step_load = (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_ON;
            fresh_q   <= 1'b0;
            up_pend_q <= 1'b0;
            dn_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fresh_q <= step_load;
            if (up_go)
                up_pend_q <= 1'b0;
            else if (up_req && (down_seq || dn_go))
                up_pend_q <= 1'b1;
            if (dn_go)
                dn_pend_q <= 1'b0;
            else if (dn_req && (up_seq || up_go))
                dn_pend_q <= 1'b1;
        end
    end

    always_comb begin
        iso_o       = 1'b0;
        sw_off_o    = 1'b0;
        dom_rst_n_o = 1'b1;
        retained_o  = 1'b0;
        save_o      = 1'b0;
        restore_o   = 1'b0;
        done_o      = 1'b0;
        on_o        = 1'b0;
        unique case (state_q)
            S_ON: begin
                on_o   = 1'b1;
                done_o = fresh_q;
            end
            S_ISO: iso_o = 1'b1;
            S_SAVE: begin
                iso_o      = 1'b1;
                retained_o = 1'b1;
                save_o     = fresh_q;
            end
            S_CUT: begin
                iso_o      = 1'b1;
                retained_o = 1'b1;
                sw_off_o   = 1'b1;
            end
            S_OFF: begin
                iso_o      = 1'b1;
                retained_o = 1'b1;
                sw_off_o   = 1'b1;
                done_o     = fresh_q;
            end
            S_PWR: begin
                iso_o      = 1'b1;
                retained_o = 1'b1;
            end
            S_RST: begin
                iso_o       = 1'b1;
                retained_o  = 1'b1;
                dom_rst_n_o = 1'b0;
            end
            S_REST: begin
                iso_o     = 1'b1;
                restore_o = fresh_q;
            end
        endcase
    end

    // R2: state saving and switch-off only happen behind isolation
    a_r2_save_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |-> iso_o);
    a_r2_cut_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off_o |-> iso_o);
    // R3: isolation is released only after the restore step
    a_r3_release_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_o) |-> ($past(state_q) == S_REST));
    // R5: strobes are single-cycle
    a_r5_save_single: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |=> !save_o);
    a_r5_restore_single: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |=> !restore_o);
    // R7: done is a one-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8: at most one request is ever held
    a_r8_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_pend_q && dn_pend_q));
    // R12: domain reset never asserted with the supply open
    a_r12_reset_powered: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_rst_n_o |-> !sw_off_o);
endmodule

// File: rtl/power_gate_seq.sv
module power_gate_seq #(
    parameter int WAIT_W       = 8,
    parameter int DATA_W       = 8,
    parameter int RETAIN_STYLE = 0,
    parameter int CLAMP_MODE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn_req,
    input  logic              pwr_up_req,
    input  logic [WAIT_W-1:0] step_wait,
    input  logic [DATA_W-1:0] dom_data_in,
    output logic [DATA_W-1:0] dom_data_out,
    output logic              iso_en,
    output logic              save_p,
    output logic              restore_p,
    output logic              retain_n,
    output logic              pwr_off,
    output logic              dom_rst_n,
    output logic              seq_done,
    output logic              dom_on
);
    localparam bit USE_LEVEL = (RETAIN_STYLE != 0);

    logic step_load, step_expire;
    logic retained, save_s, restore_s;

    pgs_step_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (step_load),
        .wait_in (step_wait),
        .expire  (step_expire)
    );

    pgs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dn_req      (pwr_dn_req),
        .up_req      (pwr_up_req),
        .step_expire (step_expire),
        .step_load   (step_load),
        .iso_o       (iso_en),
        .sw_off_o    (pwr_off),
        .dom_rst_n_o (dom_rst_n),
        .retained_o  (retained),
        .save_o      (save_s),
        .restore_o   (restore_s),
        .done_o      (seq_done),
        .on_o        (dom_on)
    );

    pgs_iso_clamp #(.DATA_W(DATA_W), .CLAMP_MODE(CLAMP_MODE)) u_clamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .iso_en (iso_en),
        .d      (dom_data_in),
        .q      (dom_data_out)
    );

    assign retain_n  = ~(retained & USE_LEVEL);
    assign save_p    = save_s & ~USE_LEVEL;
    assign restore_p = restore_s & ~USE_LEVEL;

    // R6: retention level only held while isolated
    a_r6_retain_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !retain_n |-> iso_en);
    // R7: done only on arrival at an idle state
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (dom_on || pwr_off));
endmodule

// File: tb/tb_power_gate_seq.sv
module tb_power_gate_seq;
    localparam int WAIT_W = 8;
    localparam int DATA_W = 8;
    localparam int K_ISO_ON = 0, K_ISO_OFF = 1, K_SAVE = 2, K_REST = 3, K_RET_LO = 4,
                   K_RET_HI = 5, K_CUT_ON = 6, K_CUT_OFF = 7, K_RST_LO = 8,
                   K_RST_HI = 9, K_DONE = 10;

    typedef struct { int cyc; int kind; } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dn_req = 1'b0, up_req = 1'b0;
    logic [WAIT_W-1:0] step_wait = 8'd3;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout, r_dout;
    logic iso_en, save_p, restore_p, retain_n, pwr_off, dom_rst_n, seq_done, dom_on;
    logic r_iso, r_save, r_restore, r_retain_n, r_off, r_rst_n, r_done, r_on;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    ev_t q[$];
    bit bad_ret = 0, bad_str = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    power_gate_seq #(.WAIT_W(WAIT_W), .DATA_W(DATA_W), .RETAIN_STYLE(0), .CLAMP_MODE(2)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn_req(dn_req), .pwr_up_req(up_req),
        .step_wait(step_wait), .dom_data_in(din), .dom_data_out(dout),
        .iso_en(iso_en), .save_p(save_p), .restore_p(restore_p), .retain_n(retain_n),
        .pwr_off(pwr_off), .dom_rst_n(dom_rst_n), .seq_done(seq_done), .dom_on(dom_on));

    power_gate_seq #(.WAIT_W(WAIT_W), .DATA_W(DATA_W), .RETAIN_STYLE(1), .CLAMP_MODE(1)) dut_ret (
        .clk(clk), .rst_n(rst_n), .pwr_dn_req(dn_req), .pwr_up_req(up_req),
        .step_wait(step_wait), .dom_data_in(din), .dom_data_out(r_dout),
        .iso_en(r_iso), .save_p(r_save), .restore_p(r_restore), .retain_n(r_retain_n),
        .pwr_off(r_off), .dom_rst_n(r_rst_n), .seq_done(r_done), .dom_on(r_on));

    function automatic string req_of(int k);
        case (k)
            K_ISO_ON, K_CUT_ON:   return "R2";
            K_ISO_OFF, K_CUT_OFF: return "R3";
            K_SAVE, K_REST:       return "R5";
            K_RET_LO, K_RET_HI:   return "R6";
            K_RST_LO, K_RST_HI:   return "R12";
            default:              return "R7";
        endcase
    endfunction

    task automatic chk(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic push(int c, int k);
        ev_t e;
        e.cyc = c;
        e.kind = k;
        q.push_back(e);
    endtask

    // expected down sequence starting at cycle s with step length n (R2, R5, R6, R7)
    task automatic exp_down(int s, int n);
        push(s, K_ISO_ON);
        push(s + n, K_SAVE);
        push(s + n, K_RET_LO);
        push(s + 2 * n, K_CUT_ON);
        push(s + 3 * n, K_DONE);
    endtask

    // expected up sequence (R3, R5, R6, R12, R7)
    task automatic exp_up(int s, int n);
        push(s, K_CUT_OFF);
        push(s + n, K_RST_LO);
        push(s + 2 * n, K_REST);
        push(s + 2 * n, K_RET_HI);
        push(s + 2 * n, K_RST_HI);
        push(s + 3 * n, K_ISO_OFF);
        push(s + 3 * n, K_DONE);
    endtask

    task automatic pulse(bit d, bit u, output int s);
        @(negedge clk);
        dn_req = d;
        up_req = u;
        s = cyc + 1;
        @(negedge clk);
        dn_req = 0;
        up_req = 0;
    endtask

    task automatic settle();
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: one event per observed transition or pulse cycle, in kind order
    task automatic see(int k);
        ev_t e;
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL %s: actual unexpected kind %0d at cycle %0d expected no event",
                     req_of(k), k, cyc);
        end else begin
            e = q.pop_front();
            if (e.cyc != cyc || e.kind != k) begin
                errors++;
                $display("FAIL %s: actual kind %0d at cycle %0d expected kind %0d at cycle %0d",
                         req_of(e.kind), k, cyc, e.kind, e.cyc);
            end
        end
    endtask

    logic p_iso = 0, p_ret = 1, p_off = 0, p_rst = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (iso_en && !p_iso)         see(K_ISO_ON);
            if (!iso_en && p_iso)         see(K_ISO_OFF);
            if (save_p)                   see(K_SAVE);
            if (restore_p)                see(K_REST);
            if (!r_retain_n && p_ret)     see(K_RET_LO);
            if (r_retain_n && !p_ret)     see(K_RET_HI);
            if (pwr_off && !p_off)        see(K_CUT_ON);
            if (!pwr_off && p_off)        see(K_CUT_OFF);
            if (!dom_rst_n && p_rst)      see(K_RST_LO);
            if (dom_rst_n && !p_rst)      see(K_RST_HI);
            if (seq_done)                 see(K_DONE);
            if (r_save || r_restore)      bad_ret = 1;
            if (!retain_n)                bad_str = 1;
        end
        p_iso = iso_en;
        p_ret = r_retain_n;
        p_off = pwr_off;
        p_rst = dom_rst_n;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s;
        int s2;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dom_on == 1 && iso_en == 0 && pwr_off == 0 && dom_rst_n == 1, "R1",
            {dom_on, iso_en, pwr_off, dom_rst_n}, 4'b1001);
        chk(r_retain_n == 1 && save_p == 0 && restore_p == 0 && seq_done == 0, "R1",
            {r_retain_n, save_p, restore_p, seq_done}, 4'b1000);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R11 pass-through, then R2 down with N=3 and clamping
        step_wait = 8'd3;
        din = 8'hA5;
        #1;
        chk(dout == 8'hA5, "R11", dout, 8'hA5);
        chk(r_dout == 8'hA5, "R11", r_dout, 8'hA5);
        pulse(1, 0, s);
        exp_down(s, 3);
        din = 8'h3C;
        #1;
        chk(dout == 8'hA5, "R11", dout, 8'hA5);
        chk(r_dout == 8'hFF, "R11", r_dout, 8'hFF);
        settle();
        chk(dom_on == 0 && pwr_off == 1, "R7", {dom_on, pwr_off}, 2'b01);
        // R9: down while off is ignored
        pulse(1, 0, s);
        repeat (6) @(negedge clk);
        chk(pwr_off == 1 && iso_en == 1, "R9", {pwr_off, iso_en}, 2'b11);
        // R3 up with N=3
        pulse(0, 1, s);
        exp_up(s, 3);
        settle();
        chk(dom_on == 1 && iso_en == 0, "R7", {dom_on, iso_en}, 2'b10);
        chk(dout == 8'h3C, "R11", dout, 8'h3C);

        // R9: up while on is ignored
        pulse(0, 1, s);
        repeat (6) @(negedge clk);
        chk(dom_on == 1 && pwr_off == 0, "R9", {dom_on, pwr_off}, 2'b10);

        // R4: step_wait of 0 behaves as 1
        step_wait = 8'd0;
        pulse(1, 0, s);
        exp_down(s, 1);
        settle();
        pulse(0, 1, s);
        exp_up(s, 1);
        settle();

        // R8: up during down is held, second down ignored (R9)
        step_wait = 8'd2;
        pulse(1, 0, s);
        exp_down(s, 2);
        exp_up(s + 7, 2);
        pulse(0, 1, s2);
        pulse(1, 0, s2);
        settle();
        chk(dom_on == 1, "R8", dom_on, 1);

        // R8 reverse: down during up
        pulse(1, 0, s);
        exp_down(s, 2);
        settle();
        pulse(0, 1, s);
        exp_up(s, 2);
        exp_down(s + 7, 2);
        pulse(1, 0, s2);
        settle();
        chk(pwr_off == 1, "R8", pwr_off, 1);

        // R10: both at once while off -> up first, down held
        pulse(1, 1, s);
        exp_up(s, 2);
        exp_down(s + 7, 2);
        settle();
        chk(pwr_off == 1 && dom_on == 0, "R10", {pwr_off, dom_on}, 2'b10);
        pulse(0, 1, s);
        exp_up(s, 2);
        settle();
        // R10: both at once while on -> down first, up held
        step_wait = 8'd4;
        pulse(1, 1, s);
        exp_down(s, 4);
        exp_up(s + 13, 4);
        settle();
        chk(dom_on == 1, "R10", dom_on, 1);

        chk(q.size() == 0, "R7", q.size(), 0);
        chk(!bad_ret, "R6", bad_ret, 0);
        chk(!bad_str, "R5", bad_str, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule